// File: doc/BRIEF.md
# Packet Beat FIFO with Valid-Qualified Stream Output

This block buffers the beats of outgoing packets on a single clock and hands them to a transmit streaming sink. The write side packs each beat into one wide word that carries a data payload together with start-of-packet and end-of-packet flags. The read side pops a word on its own whenever the buffer holds something and the sink is ready. The storage has a registered read port that does not look ahead, so a popped word appears on the stream outputs one clock after the pop.

The storage output register keeps the last word read until the next pop. The sop and eop outputs can therefore stay high through idle cycles. A registered valid signal marks the cycles that carry a freshly popped word. A consumer samples data, sop and eop only when valid and ready are both high, and ignores them at all other times. The write side sees the full and empty flags and the occupancy count. A synchronous clear empties the buffer.

Top module: `pkt_tx_fifo`

## Requirements
- R1: A written word is DATA_W+4 bits wide (132 at the default). Bits DATA_W-1:0 are the payload, bit DATA_W+3 (131) is start-of-packet, bit DATA_W (128) is end-of-packet, and bits DATA_W+2:DATA_W+1 are unused. Words leave on st_data, st_sop and st_eop in the order they were written.
- R2: A pop happens in exactly the cycles where fifo_empty is low and st_ready is high.
- R3: st_valid is high in the cycle after a pop, and the popped word is on the outputs in that cycle.
- R4: st_valid is low in the cycle after a cycle without a pop. st_data, st_sop and st_eop then keep the last word popped.
- R5: A write request while fifo_full is high is ignored: the count does not change and the stored words are not disturbed.
- R6: The count rises by one after a write-only cycle and falls by one after a pop-only cycle. It is unchanged after a cycle with both a write and a pop, or with neither.
- R7: fifo_empty is high exactly when the count is 0. fifo_full is high exactly when the count equals DEPTH.
- R8: When sclr is high at a clock edge, the next cycle shows count 0, fifo_empty high, fifo_full low, st_valid low, and all-zero st_data, st_sop and st_eop.
- R9: While st_ready is low, no word is popped, and st_valid is low from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sclr | input | 1 | Synchronous clear, active high |
| wr_word | input | DATA_W+4 (132) | Packed beat: payload, sop at bit 131, eop at bit 128 |
| wr_req | input | 1 | Write request |
| st_ready | input | 1 | Sink ready |
| st_data | output | DATA_W (128) | Payload of the last word popped |
| st_sop | output | 1 | Start-of-packet flag of the last word popped |
| st_eop | output | 1 | End-of-packet flag of the last word popped |
| st_valid | output | 1 | Qualifies st_data, st_sop and st_eop |
| fifo_full | output | 1 | Count equals DEPTH |
| fifo_empty | output | 1 | Count is zero |
| fifo_used | output | $clog2(DEPTH+1) (5) | Number of stored words |

## Verification
The bench runs with a depth of four, so full, empty and pointer wrap are reached often. It fills past capacity with the sink stalled: a design that let an overflowing write through would overwrite a queued word or wrap the count. It drains and then idles, so eop is held while valid is low: a design that dropped valid late, or that cleared the held word, shows up against the model. It also runs a long mixed sweep with simultaneous write and pop on a full buffer, sink stalls and clears in the middle of a stream, which catches count arithmetic that is off by one or a write that slips past full while a pop frees a slot.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  // Positions of the flag bits above the payload inside a stored word
  localparam int unsigned SOP_OFS = 3;
  localparam int unsigned EOP_OFS = 0;
  localparam int unsigned FLAG_BITS = 4;
endpackage

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          sclr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] used,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] used_nx;

  // A write is dropped while full, even if a pop frees a slot in the same cycle
  assign wr_en = wr_req && !full;
  assign rd_en = rd_req && !empty;

  always_comb begin
    used_nx = used;
    case ({wr_en, rd_en})
      2'b10:   used_nx = used + 1'b1;
      2'b01:   used_nx = used - 1'b1;
      default: used_nx = used;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sclr) begin
      wptr  <= '0;
      rptr  <= '0;
      used  <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (wr_en) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      used  <= used_nx;
      full  <= (used_nx == CNT_MAX);
      empty <= (used_nx == '0);
    end
  end
endmodule

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int unsigned WIDTH = 132,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             sclr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // Registered read port; holds its value between reads
  always_ff @(posedge clk) begin
    if (sclr)    q <= '0;
    else if (re) q <= ram[raddr];
  end
endmodule

// File: rtl/pkt_stream_rd.sv
module pkt_stream_rd (
  input  logic clk,
  input  logic sclr,
  input  logic empty,
  input  logic ready,
  output logic rd_req,
  output logic valid
);
  // Pop only what the sink can take this cycle
  assign rd_req = ready && !empty;

  always_ff @(posedge clk) begin
    if (sclr) valid <= 1'b0;
    else      valid <= rd_req;
  end
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned WORD_W = DATA_W + FLAG_BITS,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              sclr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_req,
  input  logic              st_ready,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop,
  output logic              st_valid,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [CW-1:0]     fifo_used
);
  logic          rd_req, wr_en, rd_en;
  logic [AW-1:0] wptr, rptr;
  logic [WORD_W-1:0] q;

  pkt_stream_rd u_rd (
    .clk    (clk),
    .sclr   (sclr),
    .empty  (fifo_empty),
    .ready  (st_ready),
    .rd_req (rd_req),
    .valid  (st_valid)
  );

  pkt_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk    (clk),
    .sclr   (sclr),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wptr   (wptr),
    .rptr   (rptr),
    .used   (fifo_used),
    .full   (fifo_full),
    .empty  (fifo_empty)
  );

  pkt_fifo_mem #(.WIDTH(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .sclr  (sclr),
    .we    (wr_en),
    .waddr (wptr),
    .wdata (wr_word),
    .re    (rd_en),
    .raddr (rptr),
    .q     (q)
  );

  assign st_data = q[DATA_W-1:0];
  assign st_sop  = q[DATA_W + SOP_OFS];
  assign st_eop  = q[DATA_W + EOP_OFS];
endmodule

// File: rtl/pkt_tx_fifo_chk.sv
module pkt_tx_fifo_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CW     = 5
) (
  input logic              clk,
  input logic              sclr,
  input logic              wr_req,
  input logic              st_ready,
  input logic [DATA_W-1:0] st_data,
  input logic              st_sop,
  input logic              st_eop,
  input logic              st_valid,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [CW-1:0]     fifo_used
);
  assert_valid_after_pop_R3: assert property (@(posedge clk) disable iff (sclr)
    (!fifo_empty && st_ready) |=> st_valid);

  assert_idle_drops_valid_R4: assert property (@(posedge clk) disable iff (sclr)
    !(!fifo_empty && st_ready) |=> !st_valid);

  assert_held_word_R4: assert property (@(posedge clk) disable iff (sclr)
    !(!fifo_empty && st_ready) |=> ($stable(st_data) && $stable(st_sop) && $stable(st_eop)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (sclr)
    (fifo_full && !st_ready) |=> (fifo_full && fifo_used == CW'(DEPTH)));

  assert_stall_no_pop_R9: assert property (@(posedge clk) disable iff (sclr)
    (!st_ready && !wr_req) |=> $stable(fifo_used));

  assert_flags_match_count_R7: assert property (@(posedge clk) disable iff (sclr)
    (fifo_empty == (fifo_used == '0)) && (fifo_full == (fifo_used == CW'(DEPTH))));

  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (sclr)
    fifo_used <= CW'(DEPTH));

  assert_clear_empties_R8: assert property (@(posedge clk)
    sclr |=> (fifo_used == '0 && fifo_empty && !fifo_full && !st_valid));
endmodule

bind pkt_tx_fifo pkt_tx_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .sclr       (sclr),
  .wr_req     (wr_req),
  .st_ready   (st_ready),
  .st_data    (st_data),
  .st_sop     (st_sop),
  .st_eop     (st_eop),
  .st_valid   (st_valid),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_used  (fifo_used)
);

// File: tb/sim_pkt_tx_fifo.sv
module sim_pkt_tx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;
  localparam int DEPTH = 4;
  localparam int WW = DW + 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          sclr = 1'b1;
  logic [WW-1:0] wr_word = '0;
  logic          wr_req = 1'b0;
  logic          st_ready = 1'b0;
  logic [DW-1:0] st_data;
  logic          st_sop, st_eop, st_valid, fifo_full, fifo_empty;
  logic [CW-1:0] fifo_used;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_tx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .sclr(sclr), .wr_word(wr_word), .wr_req(wr_req), .st_ready(st_ready),
    .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop), .st_valid(st_valid),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_used(fifo_used)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model
  logic [WW-1:0] mq [DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  logic m_valid = 0;
  logic [WW-1:0] m_word = '0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] mkword();
    logic [WW-1:0] w;
    w = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return w;
  endfunction

  // Apply one cycle of stimulus from a negedge, step the model, check at the next negedge
  task automatic step(input bit wr, input logic [WW-1:0] word, input bit rdy, input bit clr);
    bit was_full, rd, wok;
    string tv, tw, tc;
    wr_req = wr; wr_word = word; st_ready = rdy; sclr = clr;
    was_full = (m_cnt == DEPTH);
    if (clr) begin
      m_cnt = 0; m_head = 0; m_tail = 0; m_valid = 0; m_word = '0;
    end else begin
      rd  = (m_cnt != 0) && rdy;
      wok = wr && (m_cnt != DEPTH);
      if (rd) begin
        m_word = mq[m_head];
        m_head = (m_head + 1) % DEPTH;
      end
      m_valid = rd;
      if (wok) begin
        mq[m_tail] = word;
        m_tail = (m_tail + 1) % DEPTH;
      end
      m_cnt = m_cnt + int'(wok) - int'(rd);
    end
    @(posedge clk);
    @(negedge clk);
    tv = clr ? "R8" : (!rdy ? "R9" : "R3");
    tw = clr ? "R8" : (m_valid ? "R1" : "R4");
    tc = clr ? "R8" : ((wr && was_full) ? "R5" : (rdy ? "R2" : "R6"));
    check(st_valid == m_valid, tv, 256'(st_valid), 256'(m_valid));
    check({st_sop, st_eop, st_data} == {m_word[DW+3], m_word[DW], m_word[DW-1:0]}, tw,
          256'({st_sop, st_eop, st_data}), 256'({m_word[DW+3], m_word[DW], m_word[DW-1:0]}));
    check(int'(fifo_used) == m_cnt, tc, 256'(fifo_used), 256'(m_cnt));
    check(fifo_empty == (m_cnt == 0) && fifo_full == (m_cnt == DEPTH), "R7",
          256'({fifo_full, fifo_empty}), 256'({m_cnt == DEPTH, m_cnt == 0}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: reset state
    step(0, '0, 0, 1);
    step(0, '0, 0, 1);
    // R5, R9: fill past capacity with the sink stalled
    for (int i = 0; i < DEPTH + 2; i++) step(1, mkword(), 0, 0);
    // R3, R1: drain in order, with an eop-marked last beat held afterwards (R4)
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, 1, 0);
    step(1, {1'b0, 2'b00, 1'b1, 128'hA5}, 0, 0);
    step(0, '0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    // R6: write and pop together, including on a full buffer
    for (int i = 0; i < 24; i++) step(1, mkword(), (i % 3) != 0, 0);
    for (int i = 0; i < 6; i++) step(1, mkword(), 0, 0);
    for (int i = 0; i < 6; i++) step(1, mkword(), 1, 0);
    // R8: clear in the middle of a stream
    step(1, mkword(), 1, 1);
    step(0, '0, 1, 0);
    // Mixed sweep
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 6, mkword(), ($urandom % 10) < 6, ($urandom % 250) == 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule